// File: doc/BRIEF.md
# Wear-Levelled Odometer Record Store

This block keeps a distance count in tenth-units and saves it to a byte-wide nonvolatile store. The store is used as a ring of fixed-size record slots, so writes are spread over all slots and no single cell wears out quickly. Each record holds a marker byte followed by the count. The marker is cleared before the count bytes are written and is set to the valid code only after them. A save that is cut off part way therefore leaves a record that is not trusted.

After reset the block reads every slot of the store and restores the largest count found in a slot marked valid. It then raises a ready flag. From then on each pulse input adds one tenth-unit and asks for a save into the next slot of the ring. The store is reached through one request/done handshake that serves both reads and writes. Only one byte operation is outstanding at a time.

Top module: `odo_store`

## Requirements
- R1: After reset `ready_o` is low. The block reads all SLOTS*4 bytes of the store (120 by default) and writes nothing, then raises `ready_o`. `ready_o` stays high until the next reset, and `mem_re_o` is never high while `ready_o` is high.
- R2: A slot at byte address slot*4 holds a marker at offset 0 and a 24-bit count at offsets 1..3, most significant byte first. A slot is valid only if its marker is 0xA5 and its count is no more than 9,999,999. The restored count is the largest count among the valid slots.
- R3: If no slot is valid, the restored count is 0 and the first save goes to slot 0.
- R4: While ready, each clock cycle with `pulse_i` high adds one to `count_o` on the next edge. The count 9,999,999 rolls over to 0.
- R5: `pulse_i` has no effect before `ready_o` is high, and `count_o` is 0 until then.
- R6: The first save goes to the slot after the one that held the restored count. Each later save goes to the slot after the previous save. Slot 29 is followed by slot 0.
- R7: A save is exactly 5 byte writes, in this order: marker offset with 0x00, offsets 1, 2 and 3 with the count bytes (most significant first), then the marker offset with 0xA5.
- R8: `mem_we_o` and `mem_re_o` are never high together. Once raised, a request stays high with stable address and write data until `mem_done_i` is seen. `mem_done_i` is a one-cycle pulse from the store, and `mem_rdata_i` is valid in that same cycle.
- R9: Pulses that arrive during a save are counted at once. At most one further save is kept pending, and it stores the count as it is when that save starts. A burst of pulses within one save therefore ends with exactly two saves, and the last one holds the final count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | One tenth-unit per cycle high |
| count_o | output | 24 | Current distance count |
| ready_o | output | 1 | Startup scan finished |
| mem_we_o | output | 1 | Byte write request |
| mem_re_o | output | 1 | Byte read request |
| mem_addr_o | output | 7 | Byte address in the store |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte read, valid with done |
| mem_done_i | input | 1 | One-cycle completion of the request |

## Verification
The hardest case to reach is a pulse burst that falls inside a save already in progress. Here the pending request must fold many pulses into one later save, not queue one save per pulse. The stimulus drives eight pulses on back-to-back cycles while the store model adds at least one cycle of latency to each byte write. The bench then checks that exactly ten writes follow and that the last record holds the final count. Restore selection is also driven from store images preloaded during reset. These images mix dirty markers, foreign markers, out-of-range counts, the top slot and the rollover value, and the bench compares the result with a maximum it computes itself.

// File: rtl/odo_pkg.sv
package odo_pkg;
    localparam logic [7:0] MARK_VALID = 8'hA5;
    localparam logic [7:0] MARK_DIRTY = 8'h00;

    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,
        ST_IDLE = 2'd1,
        ST_SAVE = 2'd2
    } odo_st_e;
endpackage

// File: rtl/odo_ring_step.sv
module odo_ring_step #(
    parameter int SLOTS  = 30,
    parameter int SLOT_W = 5
) (
    input  logic [SLOT_W-1:0] cur_i,
    output logic [SLOT_W-1:0] nxt_o
);
    always_comb begin
        if (cur_i == SLOT_W'(SLOTS - 1)) nxt_o = '0;
        else                             nxt_o = cur_i + 1'b1;
    end
endmodule

// File: rtl/odo_rec_byte.sv
module odo_rec_byte #(
    parameter int DATA_BYTES = 3,
    parameter int CNT_W      = 24,
    parameter int BIDX_W     = 3
) (
    input  logic [BIDX_W-1:0] idx_i,
    input  logic [CNT_W-1:0]  value_i,
    output logic [7:0]        byte_o
);
    // index 0: dirty marker, 1..DATA_BYTES: count MSB first, last: valid marker
    always_comb begin
        byte_o = odo_pkg::MARK_VALID;
        if (idx_i == '0) byte_o = odo_pkg::MARK_DIRTY;
        for (int j = 0; j < DATA_BYTES; j++) begin
            if (idx_i == BIDX_W'(j + 1)) byte_o = value_i[(DATA_BYTES-1-j)*8 +: 8];
        end
    end
endmodule

// File: rtl/odo_store.sv
module odo_store #(
    parameter int SLOTS      = 30,
    parameter int DATA_BYTES = 3,
    parameter int MAX_COUNT  = 9999999,
    parameter int CNT_W      = 8 * DATA_BYTES,
    parameter int ADDR_W     = $clog2(SLOTS * (DATA_BYTES + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              ready_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    input  logic              mem_done_i
);
    import odo_pkg::*;

    localparam int REC_BYTES = DATA_BYTES + 1;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int BIDX_W    = $clog2(DATA_BYTES + 2);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_COUNT);

    typedef struct packed {
        odo_st_e           st;
        logic [SLOT_W-1:0] slot;
        logic [BIDX_W-1:0] bidx;
        logic [CNT_W-1:0]  assem;
        logic [7:0]        mark;
        logic              found;
        logic [CNT_W-1:0]  best;
        logic [SLOT_W-1:0] best_slot;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  snap;
        logic              pending;
        logic              ready;
        logic              req_we;
        logic              req_re;
    } regs_t;

    regs_t q, d;

    // candidate evaluation when the last byte of a slot arrives
    logic [CNT_W-1:0]  full_w;
    logic              take_w;
    logic              win_found;
    logic [CNT_W-1:0]  win_val;
    logic [SLOT_W-1:0] win_slot;
    logic [SLOT_W-1:0] win_next;
    logic [SLOT_W-1:0] slot_next;
    logic [BIDX_W-1:0] off_w;

    always_comb begin
        full_w    = (q.assem << 8) | CNT_W'(mem_rdata_i);
        take_w    = (q.mark == MARK_VALID) && (full_w <= TOP) &&
                    (!q.found || (full_w > q.best));
        win_found = q.found | take_w;
        win_val   = take_w ? full_w : q.best;
        win_slot  = take_w ? q.slot : q.best_slot;
    end

    odo_ring_step #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_step_cur (
        .cur_i (q.slot),
        .nxt_o (slot_next)
    );

    odo_ring_step #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_step_win (
        .cur_i (win_slot),
        .nxt_o (win_next)
    );

    odo_rec_byte #(.DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W), .BIDX_W(BIDX_W)) u_byte (
        .idx_i   (q.bidx),
        .value_i (q.snap),
        .byte_o  (mem_wdata_o)
    );

    always_comb begin
        d = q;

        if (q.ready && pulse_i) begin
            d.count   = (q.count == TOP) ? '0 : q.count + 1'b1;
            d.pending = 1'b1;
        end

        unique case (q.st)
            ST_SCAN: begin
                d.req_re = 1'b1;
                if (mem_done_i) begin
                    if (q.bidx == '0) d.mark  = mem_rdata_i;
                    else              d.assem = full_w;
                    if (q.bidx == BIDX_W'(DATA_BYTES)) begin
                        d.bidx      = '0;
                        d.found     = win_found;
                        d.best      = win_val;
                        d.best_slot = win_slot;
                        if (q.slot == SLOT_W'(SLOTS - 1)) begin
                            d.req_re = 1'b0;
                            d.st     = ST_IDLE;
                            d.ready  = 1'b1;
                            d.count  = win_found ? win_val : '0;
                            d.slot   = win_found ? win_next : '0;
                        end else begin
                            d.slot = slot_next;
                        end
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (q.pending) begin
                    d.snap    = q.count;
                    d.pending = q.ready && pulse_i;
                    d.bidx    = '0;
                    d.req_we  = 1'b1;
                    d.st      = ST_SAVE;
                end
            end
            ST_SAVE: begin
                if (mem_done_i) begin
                    if (q.bidx == BIDX_W'(DATA_BYTES + 1)) begin
                        d.req_we = 1'b0;
                        d.slot   = slot_next;
                        d.bidx   = '0;
                        d.st     = ST_IDLE;
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        off_w      = (q.bidx > BIDX_W'(DATA_BYTES)) ? '0 : q.bidx;
        mem_addr_o = ADDR_W'(q.slot) * ADDR_W'(REC_BYTES) + ADDR_W'(off_w);
    end

    assign count_o  = q.count;
    assign ready_o  = q.ready;
    assign mem_we_o = q.req_we;
    assign mem_re_o = q.req_re;
endmodule

// File: rtl/odo_store_chk.sv
module odo_store_chk #(
    parameter int MAX_COUNT = 9999999,
    parameter int CNT_W     = 24,
    parameter int ADDR_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pulse_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              ready_o,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [7:0]        mem_wdata_o,
    input logic              mem_done_i
);
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o)); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) && !mem_done_i |=>
        (mem_we_o || mem_re_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R8
    AST_NO_WRITE_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> !mem_we_o); // R1
    AST_NO_READ_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !mem_re_o); // R1
    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o); // R1
    AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> count_o == '0); // R5
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && !pulse_i |=> $stable(count_o)); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && pulse_i |=> count_o == (($past(count_o) == CNT_W'(MAX_COUNT)) ?
        '0 : $past(count_o) + 1'b1)); // R4
endmodule

bind odo_store odo_store_chk #(
    .MAX_COUNT (MAX_COUNT),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_i     (pulse_i),
    .count_o     (count_o),
    .ready_o     (ready_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_done_i  (mem_done_i)
);

// File: tb/tb_odo_store.sv
`timescale 1ns/1ps
module tb_odo_store;
    localparam int NS   = 30;
    localparam int NB   = NS * 4;
    localparam int TOPV = 9999999;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse = 1'b0;
    logic [23:0] count;
    logic        ready, we, re, done;
    logic [6:0]  addr;
    logic [7:0]  wdata, rdata;

    always #2.5 clk = ~clk;

    odo_store dut (
        .clk (clk), .rst_n (rst_n), .pulse_i (pulse), .count_o (count),
        .ready_o (ready), .mem_we_o (we), .mem_re_o (re), .mem_addr_o (addr),
        .mem_wdata_o (wdata), .mem_rdata_i (rdata), .mem_done_i (done)
    );

    // store model
    logic [7:0] pre [0:NB-1];
    logic [7:0] mem [0:NB-1];
    logic [6:0] log_a [0:255];
    logic [7:0] log_d [0:255];
    int wlog, rd_cnt, lat;
    logic busy;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) mem[i] <= pre[i];
            done <= 1'b0; busy <= 1'b0; wlog <= 0; rd_cnt <= 0; rdata <= 8'h00;
        end else if (done) begin
            done <= 1'b0; busy <= 1'b0;
        end else if (busy) begin
            if (lat == 0) begin
                done  <= 1'b1;
                rdata <= mem[addr];
                if (re) rd_cnt <= rd_cnt + 1;
                if (we) begin
                    mem[addr] <= wdata;
                    if (wlog < 256) begin
                        log_a[wlog] <= addr; log_d[wlog] <= wdata;
                    end
                    wlog <= wlog + 1;
                end
            end else lat <= lat - 1;
        end else if (we || re) begin
            busy <= 1'b1;
            lat  <= int'($urandom % 4);
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put_slot(input int s, input logic [7:0] m, input int v);
        pre[s*4]   = m;
        pre[s*4+1] = v[23:16];
        pre[s*4+2] = v[15:8];
        pre[s*4+3] = v[7:0];
    endtask

    task automatic blank();
        for (int i = 0; i < NB; i++) pre[i] = 8'hFF;
    endtask

    // expected restore from the preload image
    task automatic expect_boot(output int val, output int nxt);
        bit f = 0;
        int bs = 0;
        val = 0;
        for (int s = 0; s < NS; s++) begin
            int v = {8'h00, pre[s*4+1], pre[s*4+2], pre[s*4+3]};
            if (pre[s*4] == 8'hA5 && v <= TOPV && (!f || v > val)) begin
                f = 1; val = v; bs = s;
            end
        end
        nxt = f ? (bs + 1) % NS : 0;
    endtask

    task automatic boot(input bit pulse_in_scan);
        rst_n = 1'b0; pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        if (pulse_in_scan) begin
            repeat (20) @(negedge clk);
            pulse = 1'b1; @(negedge clk); pulse = 1'b0;
        end
        for (int i = 0; i < 5000 && !ready; i++) @(negedge clk);
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); pulse = 1'b1;
        end
        @(negedge clk); pulse = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        for (int i = 0; i < 2000 && q < 4; i++) begin
            @(negedge clk);
            q = (we || re) ? 0 : q + 1;
        end
    endtask

    function automatic int mem_val(input int s);
        return {8'h00, mem[s*4+1], mem[s*4+2], mem[s*4+3]};
    endfunction

    // every logged save: order, markers, ring succession; first base given
    task automatic check_saves(input int first_slot);
        int pb = 0;
        chk("R7 write count multiple of 5", wlog % 5, 0);
        for (int g = 0; g < wlog / 5; g++) begin
            int b = log_a[5*g];
            chk("R7 dirty marker first", log_d[5*g], 0);
            chk("R7 data offset 1", log_a[5*g+1], b + 1);
            chk("R7 data offset 2", log_a[5*g+2], b + 2);
            chk("R7 data offset 3", log_a[5*g+3], b + 3);
            chk("R7 marker addr last", log_a[5*g+4], b);
            chk("R7 valid marker last", log_d[5*g+4], 8'hA5);
            if (g == 0) chk("R6 first save slot", b, first_slot * 4);
            else        chk("R6 ring succession", b, (pb + 4) % NB);
            pb = b;
        end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int ev, en;
        void'($urandom(32'd20240226));
        blank();

        // reset state
        @(negedge clk);
        chk("R1 ready low in reset", ready, 0);
        chk("R5 count zero in reset", count, 0);
        chk("R1 no write in reset", we, 0);

        // empty store, pulse during scan ignored
        boot(1);
        chk("R1 ready after scan", ready, 1);
        chk("R1 all bytes read", rd_cnt, NB);
        chk("R1 no writes during scan", wlog, 0);
        chk("R3 empty store restores 0", count, 0);
        chk("R5 scan pulse ignored", count, 0);
        pulses(1);
        chk("R4 one pulse adds one", count, 1);
        wait_quiet();
        chk("R7 five writes per save", wlog, 5);
        chk("R3 first save slot 0", log_a[0], 0);
        chk("R7 MSB byte", log_d[1], 0);
        chk("R7 LSB byte", log_d[3], 1);
        check_saves(0);

        // max over valid slots, others rejected
        blank();
        put_slot(3, 8'hA5, 500);
        put_slot(10, 8'hA5, 1234);
        put_slot(7, 8'h00, 99999);
        put_slot(12, 8'h5A, 888888);
        put_slot(20, 8'hA5, 24'hFFFFFF);
        boot(0);
        chk("R2 largest valid restored", count, 1234);
        pulses(1);
        wait_quiet();
        check_saves(11);
        chk("R6 saved after restored slot", mem_val(11), 1235);
        chk("R2 old record untouched", mem_val(10), 1234);

        // wrap of the ring from slot 29
        blank();
        put_slot(29, 8'hA5, 42);
        boot(0);
        chk("R2 top slot restored", count, 42);
        pulses(1); wait_quiet();
        pulses(1); wait_quiet();
        check_saves(0);
        chk("R6 wrapped save slot 0", mem_val(0), 43);
        chk("R6 next save slot 1", mem_val(1), 44);

        // rollover of the count
        blank();
        put_slot(5, 8'hA5, TOPV);
        boot(0);
        chk("R2 top value restored", count, TOPV);
        pulses(1);
        chk("R4 rollover to 0", count, 0);
        wait_quiet();
        check_saves(6);
        chk("R4 rollover saved", mem_val(6), 0);

        // burst during a save
        blank();
        put_slot(2, 8'hA5, 700);
        boot(0);
        pulses(8);
        chk("R9 burst all counted", count, 708);
        wait_quiet();
        chk("R9 exactly two saves", wlog, 10);
        check_saves(3);
        chk("R9 last save holds final count", mem_val(4), 708);
        chk("R9 first save marker valid", mem[12], 8'hA5);

        // random images
        for (int it = 0; it < 6; it++) begin
            int k;
            for (int s = 0; s < NS; s++) begin
                int r = int'($urandom % 4);
                logic [7:0] m = (r == 1) ? 8'h00 : (r == 3) ? 8'($urandom) : 8'hA5;
                put_slot(s, m, int'($urandom % 10500000));
            end
            if (it == 0) for (int s = 0; s < NS; s++) pre[s*4] = 8'h00;
            expect_boot(ev, en);
            boot(it % 2);
            chk("R2 random restore", count, ev);
            k = 1 + int'($urandom % 3);
            for (int p = 0; p < k; p++) begin
                pulses(1);
                repeat (int'($urandom % 30)) @(negedge clk);
            end
            chk("R4 random pulses counted", count, (ev + k) % (TOPV + 1));
            wait_quiet();
            check_saves(en);
            chk("R9 final count stored", mem_val(log_a[wlog-1] / 4), (ev + k) % (TOPV + 1));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule